// File: doc/BRIEF.md
# Two-Cluster Thread-Aware Memory Request Arbiter

This block picks, once per clock, which entry of a shared memory request buffer is served next. The buffer holds requests from several hardware threads. Each request carries a thread id, a bank, a row and an arrival sequence number, and the arbiter also sees which row is open in every bank. The arbiter counts how many grants each thread receives during a quantum. At every quantum boundary it uses those counts to split the threads into a light cluster and a heavy cluster.

Light threads always beat heavy threads. Inside the light cluster the thread that used memory least ranks first. Inside the heavy cluster the rank order rotates by one place at every shuffle tick, so no heavy thread stays last for long. A programmable threshold moves the split point. It trades throughput (more threads treated as light) against fairness (more threads rotated). Within one thread rank, an open-row hit wins, then the oldest request. The grant is registered and appears one cycle after the request snapshot it was chosen from.

Top module: `thread_cluster_arb`

## Requirements
- R1: During and right after reset, `gnt_valid` is 0. Every thread is light, and thread ranks follow thread id, with id 0 ranked best.
- R2: A cycle with no valid entry yields `gnt_valid` = 0 one cycle later. Otherwise `gnt_valid` = 1 and `gnt_idx` names an entry that was valid in the previous cycle.
- R3: A request from a light-cluster thread is always granted ahead of any request from a heavy-cluster thread, whatever the row hits and ages.
- R4: Among light threads, the thread with the smaller grant count in the last quantum ranks first. Equal counts rank by lower thread id.
- R5: At a quantum boundary, threads are sorted by ascending count (ties by id). A thread is light when 16 × (running sum of sorted counts up to and including it) ≤ `cluster_thresh` × (total count). `cluster_thresh` is in sixteenths, from 0 to 16.
- R6: Heavy threads start a quantum ranked by ascending count. At each shuffle tick (every `shuffle_len` cycles within a quantum, restarted at each boundary) the heavy order rotates by one place: the top heavy thread moves to the bottom.
- R7: Between requests of equal thread rank, one whose `req_row` equals the open row of its bank is preferred over one that misses.
- R8: Remaining ties go to the smaller `req_seq` (older), then to the lower entry index.
- R9: Cluster membership and ranks change only at a quantum boundary. Counts gathered during a quantum have no effect on ordering until the next boundary.
- R10: A quantum boundary occurs every `quantum_len` cycles after reset. Counts restart at that boundary, with the grant chosen in the boundary cycle counted toward the new quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NENT | Entry holds a live request |
| req_tid | input | NENT*TID_W | Thread id per entry |
| req_bank | input | NENT*BANK_W | Target bank per entry |
| req_row | input | NENT*ROW_W | Target row per entry |
| req_seq | input | NENT*SEQ_W | Arrival sequence number per entry, smaller is older |
| open_row | input | NBANK*ROW_W | Row currently open in each bank |
| cluster_thresh | input | 5 | Light-cluster share of total traffic, in sixteenths |
| quantum_len | input | PER_W | Cycles per ranking quantum |
| shuffle_len | input | PER_W | Cycles per heavy-cluster rotation |
| gnt_valid | output | 1 | A grant is presented |
| gnt_idx | output | IDX_W | Buffer entry granted |

## Verification
The bench makes the light cluster compete with an older, row-hitting heavy request. A design that ranks on row hit or age first would hand that slot to the heavy thread. Two heavy threads are kept contending across several shuffle ticks, and the winner must change every tick. An arbiter that never rotates, or rotates at the wrong count, would starve one of them. Contention is also placed on the cycles around a quantum boundary, where the winner must flip exactly at the boundary. Early re-ranking would flip it too soon, and a missed count reset would keep the old order. Same-thread pairs check that a row hit beats an older miss, and that full ties fall to the smaller sequence and then the lower index.

// File: rtl/tca_pkg.sv
package tca_pkg;
  // threshold is a fraction in sixteenths
  localparam int FRAC_W     = 5;
  localparam int FRAC_SHIFT = 4;

  typedef enum logic {CL_LIGHT = 1'b0, CL_HEAVY = 1'b1} cluster_e;
endpackage

// File: rtl/tca_epoch_timer.sv
module tca_epoch_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] quantum_len,
  input  logic [PER_W-1:0] shuffle_len,
  output logic             q_end,
  output logic             s_tick
);
  logic [PER_W-1:0] qcnt_q, scnt_q;
  logic [PER_W:0]   q_next, s_next;

  assign q_next = {1'b0, qcnt_q} + (PER_W+1)'(1);
  assign s_next = {1'b0, scnt_q} + (PER_W+1)'(1);
  assign q_end  = (q_next >= {1'b0, quantum_len});
  assign s_tick = !q_end && (s_next >= {1'b0, shuffle_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      scnt_q <= '0;
    end else if (q_end) begin
      qcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      qcnt_q <= q_next[PER_W-1:0];
      scnt_q <= s_tick ? '0 : s_next[PER_W-1:0];
    end
  end
endmodule

// File: rtl/tca_usage_ctr.sv
module tca_usage_ctr #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 8,
  parameter int TID_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  q_end,
  input  logic                  win_valid,
  input  logic [TID_W-1:0]      win_tid,
  output logic [NTHR*CNT_W-1:0] cnt_flat
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CNT_W-1:0] cnt_q;
    logic             hit_me;

    assign hit_me = win_valid && (win_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (q_end) begin
        cnt_q <= hit_me ? CNT_W'(1) : '0;
      end else if (hit_me && (cnt_q != '1)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign cnt_flat[t*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/tca_ranker.sv
module tca_ranker
  import tca_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int CNT_W = 8,
  parameter int TID_W = 2,
  localparam int KW    = TID_W + 1,
  localparam int CW    = TID_W + 1,
  localparam int SUM_W = CNT_W + TID_W,
  localparam int PRD_W = SUM_W + FRAC_W + FRAC_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR*CNT_W-1:0] cnt_flat,
  input  logic [FRAC_W-1:0]     thresh,
  input  logic                  q_end,
  input  logic                  s_tick,
  output logic [NTHR*KW-1:0]    key_flat,
  output logic [NTHR-1:0]       heavy_mask,
  output logic [CW-1:0]         nheavy,
  output logic [CW-1:0]         rot
);
  // light test: sum/total <= thresh/16, done without division
  function automatic logic is_light(input logic [SUM_W-1:0] run,
                                    input logic [SUM_W-1:0] tot,
                                    input logic [FRAC_W-1:0] frac);
    logic [PRD_W-1:0] lhs, rhs;
    lhs = PRD_W'(run) << FRAC_SHIFT;
    rhs = PRD_W'(frac) * PRD_W'(tot);
    return lhs <= rhs;
  endfunction

  // rotated slot of a heavy thread: (hrank - r) mod nh
  function automatic logic [TID_W-1:0] heavy_slot(input logic [TID_W-1:0] pos,
                                                  input logic [CW-1:0] nh,
                                                  input logic [CW-1:0] r);
    logic [CW-1:0] hr, s;
    hr = {1'b0, pos} + nh - CW'(NTHR);
    s  = (hr >= r) ? (hr - r) : (hr + nh - r);
    return s[TID_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt      [NTHR];
  logic [TID_W-1:0] pos_n    [NTHR];
  logic [SUM_W-1:0] run_n    [NTHR];
  logic [SUM_W-1:0] total;
  logic [NTHR-1:0]  heavy_n;
  logic [CW-1:0]    nheavy_n;

  logic [TID_W-1:0] pos_q    [NTHR];
  logic [NTHR-1:0]  heavy_q;
  logic [CW-1:0]    nheavy_q;
  logic [CW-1:0]    rot_q;

  always_comb begin
    total = '0;
    for (int t = 0; t < NTHR; t++) begin
      cnt[t] = cnt_flat[t*CNT_W +: CNT_W];
      total  = total + SUM_W'(cnt[t]);
    end
  end

  // sort by (count, id) and compute each thread's inclusive running sum
  always_comb begin
    nheavy_n = '0;
    for (int t = 0; t < NTHR; t++) begin
      pos_n[t] = '0;
      run_n[t] = '0;
      for (int u = 0; u < NTHR; u++) begin
        if ((cnt[u] < cnt[t]) || ((cnt[u] == cnt[t]) && (u < t))) begin
          pos_n[t] = pos_n[t] + TID_W'(1);
          run_n[t] = run_n[t] + SUM_W'(cnt[u]);
        end else if (u == t) begin
          run_n[t] = run_n[t] + SUM_W'(cnt[u]);
        end
      end
      heavy_n[t] = !is_light(run_n[t], total, thresh);
      nheavy_n   = nheavy_n + CW'(heavy_n[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) pos_q[t] <= TID_W'(t);
      heavy_q  <= '0;
      nheavy_q <= '0;
      rot_q    <= '0;
    end else if (q_end) begin
      for (int t = 0; t < NTHR; t++) pos_q[t] <= pos_n[t];
      heavy_q  <= heavy_n;
      nheavy_q <= nheavy_n;
      rot_q    <= '0;
    end else if (s_tick) begin
      rot_q <= ((rot_q + CW'(1)) >= nheavy_q) ? '0 : (rot_q + CW'(1));
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_key
    cluster_e cl;
    assign cl = heavy_q[t] ? CL_HEAVY : CL_LIGHT;
    assign key_flat[t*KW +: KW] = (cl == CL_HEAVY)
        ? {1'b1, heavy_slot(pos_q[t], nheavy_q, rot_q)}
        : {1'b0, pos_q[t]};
  end

  assign heavy_mask = heavy_q;
  assign nheavy     = nheavy_q;
  assign rot        = rot_q;
endmodule

// File: rtl/tca_picker.sv
module tca_picker #(
  parameter int NENT   = 8,
  parameter int NTHR   = 4,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int SEQ_W  = 8,
  parameter int TID_W  = 2,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3,
  localparam int KW = TID_W + 1,
  localparam int EK = KW + 1 + SEQ_W
) (
  input  logic [NENT-1:0]        req_valid,
  input  logic [NENT*TID_W-1:0]  req_tid,
  input  logic [NENT*BANK_W-1:0] req_bank,
  input  logic [NENT*ROW_W-1:0]  req_row,
  input  logic [NENT*SEQ_W-1:0]  req_seq,
  input  logic [NBANK*ROW_W-1:0] open_row,
  input  logic [NTHR*KW-1:0]     key_flat,
  output logic                   sel_valid,
  output logic [IDX_W-1:0]       sel_idx,
  output logic [TID_W-1:0]       sel_tid,
  output logic                   sel_heavy,
  output logic                   any_light_req
);
  logic [TID_W-1:0]  tid;
  logic [BANK_W-1:0] bank;
  logic              hit;
  logic [EK-1:0]     cand, best;

  always_comb begin
    sel_valid     = 1'b0;
    sel_idx       = '0;
    sel_tid       = '0;
    best          = '1;
    any_light_req = 1'b0;
    tid           = '0;
    bank          = '0;
    hit           = 1'b0;
    cand          = '1;
    for (int i = 0; i < NENT; i++) begin
      tid  = req_tid[i*TID_W +: TID_W];
      bank = req_bank[i*BANK_W +: BANK_W];
      hit  = (req_row[i*ROW_W +: ROW_W] == open_row[bank*ROW_W +: ROW_W]);
      // lexicographic key: thread rank, row miss, age
      cand = {key_flat[tid*KW +: KW], !hit, req_seq[i*SEQ_W +: SEQ_W]};
      if (req_valid[i]) begin
        if (!key_flat[tid*KW + KW - 1]) any_light_req = 1'b1;
        if (!sel_valid || (cand < best)) begin
          sel_valid = 1'b1;
          sel_idx   = IDX_W'(i);
          sel_tid   = tid;
          best      = cand;
        end
      end
    end
    sel_heavy = sel_valid && best[EK-1];
  end
endmodule

// File: rtl/thread_cluster_arb.sv
module thread_cluster_arb
  import tca_pkg::*;
#(
  parameter int NENT  = 8,
  parameter int NTHR  = 4,
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 8,
  parameter int PER_W = 16,
  localparam int TID_W  = $clog2(NTHR),
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(NENT),
  localparam int KW     = TID_W + 1,
  localparam int CW     = TID_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NENT-1:0]        req_valid,
  input  logic [NENT*TID_W-1:0]  req_tid,
  input  logic [NENT*BANK_W-1:0] req_bank,
  input  logic [NENT*ROW_W-1:0]  req_row,
  input  logic [NENT*SEQ_W-1:0]  req_seq,
  input  logic [NBANK*ROW_W-1:0] open_row,
  input  logic [FRAC_W-1:0]      cluster_thresh,
  input  logic [PER_W-1:0]       quantum_len,
  input  logic [PER_W-1:0]       shuffle_len,
  output logic                   gnt_valid,
  output logic [IDX_W-1:0]       gnt_idx
);
  // named internal events, observed by the bound checker
  logic                  q_end, s_tick;
  logic                  sel_valid, sel_heavy, any_light_req;
  logic [IDX_W-1:0]      sel_idx;
  logic [TID_W-1:0]      sel_tid;
  logic [NTHR*CNT_W-1:0] cnt_flat;
  logic [NTHR*KW-1:0]    key_flat;
  logic [NTHR-1:0]       heavy_mask;
  logic [CW-1:0]         nheavy, rot;

  tca_epoch_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .quantum_len(quantum_len), .shuffle_len(shuffle_len),
    .q_end(q_end), .s_tick(s_tick)
  );

  tca_usage_ctr #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_usage (
    .clk(clk), .rst_n(rst_n), .q_end(q_end),
    .win_valid(sel_valid), .win_tid(sel_tid), .cnt_flat(cnt_flat)
  );

  tca_ranker #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat), .thresh(cluster_thresh),
    .q_end(q_end), .s_tick(s_tick), .key_flat(key_flat),
    .heavy_mask(heavy_mask), .nheavy(nheavy), .rot(rot)
  );

  tca_picker #(
    .NENT(NENT), .NTHR(NTHR), .NBANK(NBANK), .ROW_W(ROW_W), .SEQ_W(SEQ_W),
    .TID_W(TID_W), .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_pick (
    .req_valid(req_valid), .req_tid(req_tid), .req_bank(req_bank),
    .req_row(req_row), .req_seq(req_seq), .open_row(open_row),
    .key_flat(key_flat), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .sel_tid(sel_tid), .sel_heavy(sel_heavy), .any_light_req(any_light_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
    end else begin
      gnt_valid <= sel_valid;
      gnt_idx   <= sel_valid ? sel_idx : gnt_idx;
    end
  end
endmodule

module tca_checker #(
  parameter int NENT  = 8,
  parameter int NTHR  = 4,
  parameter int IDX_W = 3,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NENT-1:0]  req_valid,
  input logic             sel_valid,
  input logic             sel_heavy,
  input logic             any_light_req,
  input logic             q_end,
  input logic [NTHR-1:0]  heavy_mask,
  input logic [CW-1:0]    nheavy,
  input logic [CW-1:0]    rot,
  input logic             gnt_valid,
  input logic [IDX_W-1:0] gnt_idx
);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> !gnt_valid);

  assert_grant_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (($past(req_valid) & (NENT'(1) << gnt_idx)) != '0));

  assert_light_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_heavy) |-> !any_light_req);

  assert_rank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !q_end |=> $stable(heavy_mask) && $stable(nheavy));

  assert_rot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nheavy == '0) ? (rot == '0) : (rot < nheavy));

  assert_heavy_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(heavy_mask) == int'(nheavy));
endmodule

bind thread_cluster_arb tca_checker #(
  .NENT(NENT), .NTHR(NTHR), .IDX_W(IDX_W), .CW(CW)
) u_tca_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel_valid(sel_valid),
  .sel_heavy(sel_heavy), .any_light_req(any_light_req), .q_end(q_end),
  .heavy_mask(heavy_mask), .nheavy(nheavy), .rot(rot),
  .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
);

// File: tb/thread_cluster_arb_bench.sv
module thread_cluster_arb_bench;
  localparam int NENT = 8, NTHR = 4, NBANK = 4, ROW_W = 8, SEQ_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_valid = '0;
  logic [15:0] req_tid = '0;
  logic [15:0] req_bank = '0;
  logic [63:0] req_row = '0;
  logic [63:0] req_seq = '0;
  logic [31:0] open_row = '0;
  logic [4:0]  cluster_thresh = 5'd16;
  logic [15:0] quantum_len = 16'd64;
  logic [15:0] shuffle_len = 16'd4;
  logic        gnt_valid;
  logic [2:0]  gnt_idx;

  always #10 clk = ~clk;  // 50 MHz

  thread_cluster_arb u_thread_cluster_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_bank(req_bank), .req_row(req_row), .req_seq(req_seq),
    .open_row(open_row), .cluster_thresh(cluster_thresh),
    .quantum_len(quantum_len), .shuffle_len(shuffle_len),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // scoreboard queues
  bit    sb_v[$];
  int    sb_i[$];
  string sb_t[$];

  // reference state, rebuilt from the requirements
  int m_cnt[NTHR], m_pos[NTHR];
  bit m_heavy[NTHR];
  int m_nheavy, m_rot, m_q, m_s;

  task automatic model_reset();
    for (int t = 0; t < NTHR; t++) begin
      m_cnt[t] = 0; m_pos[t] = t; m_heavy[t] = 1'b0;
    end
    m_nheavy = 0; m_rot = 0; m_q = 0; m_s = 0;
  endtask

  task automatic model_pick(output bit ev, output int ei, output int et);
    int best;
    ev = 1'b0; ei = 0; et = 0; best = 0;
    for (int i = 0; i < NENT; i++) begin
      if (req_valid[i]) begin
        int t, b, k, score;
        bit hit;
        t   = int'(req_tid[i*2 +: 2]);
        b   = int'(req_bank[i*2 +: 2]);
        hit = (req_row[i*8 +: 8] == open_row[b*8 +: 8]);
        if (!m_heavy[t]) k = m_pos[t];
        else k = (m_pos[t] - (NTHR - m_nheavy) - m_rot + m_nheavy) % m_nheavy;
        score = (((int'(m_heavy[t]) * 8 + k) * 2 + (hit ? 0 : 1)) * 256)
                + int'(req_seq[i*8 +: 8]);
        if (!ev || score < best) begin
          ev = 1'b1; ei = i; et = t; best = score;
        end
      end
    end
  endtask

  task automatic model_step(input bit ev, input int et);
    if (m_q + 1 >= int'(quantum_len)) begin
      int total, run;
      bit used[NTHR];
      total = 0; run = 0; m_nheavy = 0;
      for (int t = 0; t < NTHR; t++) begin total += m_cnt[t]; used[t] = 1'b0; end
      for (int r = 0; r < NTHR; r++) begin
        int pick;
        pick = -1;
        for (int t = 0; t < NTHR; t++)
          if (!used[t] && (pick < 0 || m_cnt[t] < m_cnt[pick])) pick = t;
        used[pick]    = 1'b1;
        m_pos[pick]   = r;
        run          += m_cnt[pick];
        m_heavy[pick] = !(run * 16 <= int'(cluster_thresh) * total);
        if (m_heavy[pick]) m_nheavy++;
      end
      for (int t = 0; t < NTHR; t++) m_cnt[t] = 0;
      if (ev) m_cnt[et] = 1;
      m_q = 0; m_s = 0; m_rot = 0;
    end else begin
      m_q++;
      if (ev && m_cnt[et] < 255) m_cnt[et]++;
      if (m_s + 1 >= int'(shuffle_len)) begin
        m_s = 0;
        m_rot = (m_rot + 1 >= m_nheavy) ? 0 : m_rot + 1;
      end else m_s++;
    end
  endtask

  // driver: inputs already placed; push expectation, advance model, next cycle
  task automatic drive(input string tag);
    bit ev; int ei, et;
    model_pick(ev, ei, et);
    sb_v.push_back(ev); sb_i.push_back(ei); sb_t.push_back(tag);
    model_step(ev, et);
    @(posedge clk); #4;
  endtask

  task automatic clr();
    req_valid = '0;
  endtask

  task automatic put(input int i, input int t, input int b, input int row, input int seq);
    req_valid[i]        = 1'b1;
    req_tid[i*2 +: 2]   = 2'(t);
    req_bank[i*2 +: 2]  = 2'(b);
    req_row[i*8 +: 8]   = 8'(row);
    req_seq[i*8 +: 8]   = 8'(seq);
  endtask

  task automatic solo(input int t, input int n, input string tag);
    clr(); put(0, t, 0, 8'h10, 0);
    for (int k = 0; k < n; k++) drive(tag);
  endtask

  task automatic idle_to_boundary(input string tag);
    clr();
    do drive(tag); while (m_q != 0);
  endtask

  // monitor: pops one expectation per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb_v.size() > 0) begin
        bit ev; int ei; string tg;
        ev = sb_v.pop_front(); ei = sb_i.pop_front(); tg = sb_t.pop_front();
        n_checks++;
        if (gnt_valid !== ev || (ev && int'(gnt_idx) != ei)) begin
          n_fail++;
          $display("FAIL %s: gnt_valid=%0b gnt_idx=%0d expected valid=%0b idx=%0d",
                   tg, gnt_valid, gnt_idx, ev, ei);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NBANK; b++) open_row[b*8 +: 8] = 8'(8'h10 + b);
    model_reset();
    repeat (3) @(posedge clk);
    #4;
    n_checks++;
    if (gnt_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: gnt_valid=%0b in reset, expected 0", gnt_valid);
    end
    rst_n = 1'b1;

    // R2: empty buffer
    clr(); drive("R2"); drive("R2");
    // R7: same thread, hit beats an older miss
    put(2, 1, 0, 8'h33, 1); put(5, 1, 1, 8'h11, 9); drive("R7");
    // R8: both hit, smaller sequence wins
    put(2, 1, 0, 8'h10, 7); put(5, 1, 1, 8'h11, 3); drive("R8");
    // R8: full tie, lower index wins
    clr(); put(1, 2, 2, 8'h12, 4); put(6, 2, 3, 8'h13, 4); drive("R8");
    // R1/R4: reset ranks by id, thread 1 beats thread 3
    clr(); put(0, 3, 0, 8'h10, 0); put(7, 1, 0, 8'h10, 5); drive("R4");
    drive("R9");
    // build quantum traffic
    solo(0, 10, "R10"); solo(2, 6, "R10"); solo(3, 1, "R10");
    idle_to_boundary("R2");

    // light cluster ordered by count: thread 3 (fewest) now first
    clr(); put(0, 0, 0, 8'h10, 0); put(3, 3, 1, 8'h22, 9); drive("R4");
    clr(); put(1, 2, 0, 8'h10, 0); put(6, 1, 2, 8'h40, 9); drive("R4");
    // traffic for a two-heavy split at a quarter threshold
    cluster_thresh = 5'd4;
    solo(3, 8, "R5"); solo(2, 6, "R5"); solo(0, 2, "R5");
    idle_to_boundary("R5");

    // R3: light thread wins against an older hit from a heavy thread
    clr(); put(0, 3, 0, 8'h10, 0); put(4, 1, 2, 8'h55, 200); drive("R3");
    clr(); put(0, 2, 0, 8'h10, 0); put(4, 0, 2, 8'h55, 200); drive("R3");
    // R6: two heavy threads contending across shuffle ticks
    clr(); put(1, 2, 0, 8'h10, 5); put(2, 3, 0, 8'h10, 5);
    for (int k = 0; k < 12; k++) drive("R6");
    // R9/R10: thread 1 collects usage, order flips only at the boundary
    solo(1, 5, "R9");
    clr();
    while (m_q + 3 < int'(quantum_len)) drive("R2");
    clr(); put(0, 0, 0, 8'h10, 9); put(5, 1, 0, 8'h10, 1);
    for (int k = 0; k < 6; k++) drive("R10");

    clr(); drive("R2"); drive("R2");
    @(posedge clk); #4;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule